// File: doc/BRIEF.md
# Unicast Egress Queue ID Resolver

This block turns the forwarding fields of a packet descriptor into the number of the unicast egress queue that the packet is placed in. Each descriptor brings a source profile, a destination port, an internal priority, a hash value, and two optional codes: a service code and a CPU code, each with its own enable. The block first selects one of three sources to address a base table. That table returns a queue base and a row number, called the profile. The profile then selects a row in two offset tables: one indexed by priority and one indexed by hash. The queue number is the base plus both offsets.

Software fills all three tables through a small register port with one write/read strobe, a table select, an index and data. Lookups are pipelined, and one descriptor can be accepted every cycle. The result appears two cycles after the input valid. An overflow flag marks any sum that does not fit in the queue number width.

The widths of the source profile, the code and port fields, the priority and the hash are parameters. With a 2-bit source profile, 8-bit codes and an 8-bit hash, the three base-table regions start at entries 0, 1024 and 2048 (3072 entries in all), and the hash table has 4096 entries. The defaults use narrower fields to keep the storage small.

Top module: `qres_resolver`

## Requirements
- R1: The base table address comes from a fixed order of precedence. If the service code is enabled, it is used. Otherwise, if the CPU code is enabled, it is used. Otherwise the destination port is used. The fields that are not selected have no effect on the result.
- R2: The base table has three regions, each S = 2^(SPROF_W+CODE_W) entries long. Destination-port entries start at 0, CPU-code entries start at S and service-code entries start at 2·S. Inside a region, the address is source_profile·2^CODE_W + code.
- R3: A base table entry holds the profile in bits [PROF_W-1:0] (bits 3:0) and the queue base in the next QID_W bits (bits 11:4).
- R4: The priority offset table is read at profile·2^PRI_W + internal priority. Each entry is a POFF_W-bit offset (4 bits) stored in bits [3:0].
- R5: The hash offset table is read at profile·2^HASH_W + hash. Each entry is a QID_W-bit offset (8 bits) stored in bits [7:0].
- R6: out_qid equals (queue base + priority offset + hash offset) mod 2^QID_W. out_ovf is 1 exactly when that sum is above 2^QID_W-1, and out_ovf is 0 whenever out_valid is 0.
- R7: After reset, every table entry reads as zero, out_valid is 0, cfg_rdata is 0, and any lookup returns queue 0 with no overflow.
- R8: A descriptor accepted with in_valid high at clock edge N gives out_valid high after edge N+1. A cycle with in_valid low gives out_valid low two edges later.
- R9: When cfg_en=1 and cfg_we=1, cfg_wdata is written to entry cfg_idx of the table picked by cfg_sel. The encodings are 0 for the base table, 1 for the priority table and 2 for the hash table. Bits of cfg_wdata above the entry width are dropped. When cfg_en=1 and cfg_we=0, the entry is returned on cfg_rdata one cycle later, zero-extended. A select of 3, or an index past the end of the chosen table, writes nothing and reads zero.
- R10: A table write made in the same cycle that a lookup reads that table is not seen by that lookup. The base table is read in the input cycle and the offset tables in the cycle after it. The write is seen by every later lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor valid |
| in_sprof | input | SPROF_W | Source profile |
| in_svc_en | input | 1 | Service code enable |
| in_svc_code | input | CODE_W | Service code |
| in_cpu_en | input | 1 | CPU code enable |
| in_cpu_code | input | CODE_W | CPU code |
| in_dport | input | CODE_W | Destination port |
| in_pri | input | PRI_W | Internal priority |
| in_hash | input | HASH_W | Packet hash value |
| out_valid | output | 1 | Result valid |
| out_qid | output | QID_W | Resolved unicast queue |
| out_ovf | output | 1 | Sum exceeded the queue range |
| cfg_en | input | 1 | Configuration access strobe |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_sel | input | 2 | Table select |
| cfg_idx | input | CFG_AW | Entry index |
| cfg_wdata | input | PROF_W+QID_W | Write data |
| cfg_rdata | output | PROF_W+QID_W | Read data, one cycle after a read |

## Verification
The tables are filled with values derived from each entry's address, so every entry is distinct. The bench then sweeps every source profile, each of the three source modes and every code value. In service mode the CPU enable is also set, and the fields that are not selected are always set to other values, so a wrong precedence or a wrong region offset gives a different queue. Separate sweeps cover all priorities and all hashes on one profile, which separates the two offset tables and their row arithmetic. Hand-placed entries give sums of exactly 255, 256 and 520 to test the wrap and the overflow flag. Writes timed against lookups in flight, together with writes using select 3, an index past the end, and data wider than the entry, show the ordering rule and the ignored accesses on the outputs.

// File: rtl/qres_pkg.sv
package qres_pkg;

  // Region number of the base table; the value orders the regions
  typedef enum logic [1:0] {
    SRC_PORT = 2'd0,
    SRC_CPU  = 2'd1,
    SRC_SVC  = 2'd2
  } qres_src_e;

  typedef enum logic [1:0] {
    TSEL_BASE = 2'd0,
    TSEL_PRI  = 2'd1,
    TSEL_HASH = 2'd2,
    TSEL_NONE = 2'd3
  } qres_tsel_e;

  // Base table address: region, then source profile, then code
  function automatic int qres_base_idx(int region, int sprof, int code,
                                       int sprof_w, int code_w);
    return (region << (sprof_w + code_w)) + (sprof << code_w) + code;
  endfunction

  // Row-major address of an offset table: profile selects the row
  function automatic int qres_row_idx(int prof, int col, int col_w);
    return (prof << col_w) + col;
  endfunction

  // Unclipped queue sum
  function automatic int qres_sum(int qbase, int poff, int hoff);
    return qbase + poff + hoff;
  endfunction

endpackage

// File: rtl/qres_index.sv
module qres_index
  import qres_pkg::*;
#(
  parameter int SPROF_W = 2,
  parameter int CODE_W  = 4,
  parameter int IDX_W   = SPROF_W + CODE_W + 2
) (
  input  logic [SPROF_W-1:0] sprof,
  input  logic               svc_en,
  input  logic [CODE_W-1:0]  svc_code,
  input  logic               cpu_en,
  input  logic [CODE_W-1:0]  cpu_code,
  input  logic [CODE_W-1:0]  dport,
  output logic [IDX_W-1:0]   idx,
  output qres_src_e          src
);

  logic [CODE_W-1:0] code_sel;

  always_comb begin
    if (svc_en) begin
      src      = SRC_SVC;
      code_sel = svc_code;
    end else if (cpu_en) begin
      src      = SRC_CPU;
      code_sel = cpu_code;
    end else begin
      src      = SRC_PORT;
      code_sel = dport;
    end
    idx = IDX_W'(qres_base_idx(int'(src), int'(sprof), int'(code_sel),
                               SPROF_W, CODE_W));
  end

endmodule

// File: rtl/qres_table.sv
module qres_table #(
  parameter int DEPTH = 256,
  parameter int W     = 8,
  parameter int AW    = 12,
  parameter int LW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [LW-1:0] lk_idx,
  output logic [W-1:0]  lk_data,
  input  logic [AW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);

  localparam int DW = $clog2(DEPTH);
  localparam logic [AW:0] LIM_A = (AW+1)'(DEPTH);
  localparam logic [LW:0] LIM_L = (LW+1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];

  // Named events for the assertion below
  logic wr_hit;
  logic lk_hit;
  logic rd_hit;

  assign wr_hit = wr_en && ({1'b0, wr_idx} < LIM_A);
  assign lk_hit = {1'b0, lk_idx} < LIM_L;
  assign rd_hit = {1'b0, rd_idx} < LIM_A;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_hit) begin
      mem[wr_idx[DW-1:0]] <= wr_data;
    end
  end

  // Reads see the contents before any write at the same edge
  assign lk_data = lk_hit ? mem[lk_idx[DW-1:0]] : '0;
  assign rd_data = rd_hit ? mem[rd_idx[DW-1:0]] : '0;

  assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> mem[$past(wr_idx[DW-1:0])] == $past(wr_data));

endmodule

// File: rtl/qres_resolver.sv
module qres_resolver
  import qres_pkg::*;
#(
  parameter int SPROF_W = 2,
  parameter int CODE_W  = 4,
  parameter int PROF_W  = 4,
  parameter int PRI_W   = 4,
  parameter int HASH_W  = 4,
  parameter int QID_W   = 8,
  parameter int POFF_W  = 4,
  parameter int CFG_AW  = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [SPROF_W-1:0]       in_sprof,
  input  logic                     in_svc_en,
  input  logic [CODE_W-1:0]        in_svc_code,
  input  logic                     in_cpu_en,
  input  logic [CODE_W-1:0]        in_cpu_code,
  input  logic [CODE_W-1:0]        in_dport,
  input  logic [PRI_W-1:0]         in_pri,
  input  logic [HASH_W-1:0]        in_hash,
  output logic                     out_valid,
  output logic [QID_W-1:0]         out_qid,
  output logic                     out_ovf,
  input  logic                     cfg_en,
  input  logic                     cfg_we,
  input  logic [1:0]               cfg_sel,
  input  logic [CFG_AW-1:0]        cfg_idx,
  input  logic [PROF_W+QID_W-1:0]  cfg_wdata,
  output logic [PROF_W+QID_W-1:0]  cfg_rdata
);

  localparam int BIDX_W     = SPROF_W + CODE_W + 2;
  localparam int REGION     = 1 << (SPROF_W + CODE_W);
  localparam int BASE_DEPTH = 3 * REGION;
  localparam int BENT_W     = PROF_W + QID_W;
  localparam int PIDX_W     = PROF_W + PRI_W;
  localparam int PRI_DEPTH  = 1 << PIDX_W;
  localparam int HIDX_W     = PROF_W + HASH_W;
  localparam int HASH_DEPTH = 1 << HIDX_W;
  localparam int CFG_DW     = BENT_W;
  localparam int QID_MAX    = (1 << QID_W) - 1;

  // Stage 0: index formation and base lookup
  logic [BIDX_W-1:0] lk_bidx;
  qres_src_e         lk_src;
  logic [BENT_W-1:0] base_ent;

  qres_index #(.SPROF_W(SPROF_W), .CODE_W(CODE_W), .IDX_W(BIDX_W)) u_index (
    .sprof    (in_sprof),
    .svc_en   (in_svc_en),
    .svc_code (in_svc_code),
    .cpu_en   (in_cpu_en),
    .cpu_code (in_cpu_code),
    .dport    (in_dport),
    .idx      (lk_bidx),
    .src      (lk_src)
  );

  // Configuration write strobes
  logic we_base, we_pri, we_hash;
  assign we_base = cfg_en && cfg_we && (cfg_sel == TSEL_BASE);
  assign we_pri  = cfg_en && cfg_we && (cfg_sel == TSEL_PRI);
  assign we_hash = cfg_en && cfg_we && (cfg_sel == TSEL_HASH);

  logic [BENT_W-1:0] rd_base;
  logic [POFF_W-1:0] rd_pri;
  logic [QID_W-1:0]  rd_hash;

  qres_table #(.DEPTH(BASE_DEPTH), .W(BENT_W), .AW(CFG_AW), .LW(BIDX_W)) u_base_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (we_base),
    .wr_idx  (cfg_idx),
    .wr_data (cfg_wdata[BENT_W-1:0]),
    .lk_idx  (lk_bidx),
    .lk_data (base_ent),
    .rd_idx  (cfg_idx),
    .rd_data (rd_base)
  );

  // Stage 1 registers
  logic               s1_valid;
  qres_src_e          s1_src;
  logic [PROF_W-1:0]  s1_prof;
  logic [QID_W-1:0]   s1_qbase;
  logic [PRI_W-1:0]   s1_pri;
  logic [HASH_W-1:0]  s1_hash;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_src   <= SRC_PORT;
      s1_prof  <= '0;
      s1_qbase <= '0;
      s1_pri   <= '0;
      s1_hash  <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_src   <= lk_src;
      s1_prof  <= base_ent[PROF_W-1:0];
      s1_qbase <= base_ent[BENT_W-1:PROF_W];
      s1_pri   <= in_pri;
      s1_hash  <= in_hash;
    end
  end

  // Stage 1: offset lookups through the profile row
  logic [PIDX_W-1:0] pidx;
  logic [HIDX_W-1:0] hidx;
  logic [POFF_W-1:0] poff;
  logic [QID_W-1:0]  hoff;

  assign pidx = PIDX_W'(qres_row_idx(int'(s1_prof), int'(s1_pri), PRI_W));
  assign hidx = HIDX_W'(qres_row_idx(int'(s1_prof), int'(s1_hash), HASH_W));

  qres_table #(.DEPTH(PRI_DEPTH), .W(POFF_W), .AW(CFG_AW), .LW(PIDX_W)) u_pri_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (we_pri),
    .wr_idx  (cfg_idx),
    .wr_data (cfg_wdata[POFF_W-1:0]),
    .lk_idx  (pidx),
    .lk_data (poff),
    .rd_idx  (cfg_idx),
    .rd_data (rd_pri)
  );

  qres_table #(.DEPTH(HASH_DEPTH), .W(QID_W), .AW(CFG_AW), .LW(HIDX_W)) u_hash_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (we_hash),
    .wr_idx  (cfg_idx),
    .wr_data (cfg_wdata[QID_W-1:0]),
    .lk_idx  (hidx),
    .lk_data (hoff),
    .rd_idx  (cfg_idx),
    .rd_data (rd_hash)
  );

  int   qsum;
  logic sum_ovf;

  always_comb begin
    qsum    = qres_sum(int'(s1_qbase), int'(poff), int'(hoff));
    sum_ovf = qsum > QID_MAX;
  end

  // Stage 2 registers: result
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_qid   <= '0;
      out_ovf   <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      out_qid   <= QID_W'(qsum);
      out_ovf   <= s1_valid && sum_ovf;
    end
  end

  // Configuration read port, one cycle of latency
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_rdata <= '0;
    end else if (cfg_en && !cfg_we) begin
      case (qres_tsel_e'(cfg_sel))
        TSEL_BASE: cfg_rdata <= CFG_DW'(rd_base);
        TSEL_PRI:  cfg_rdata <= CFG_DW'(rd_pri);
        TSEL_HASH: cfg_rdata <= CFG_DW'(rd_hash);
        default:   cfg_rdata <= '0;
      endcase
    end
  end

  assert_svc_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_svc_en) |=> (s1_src == SRC_SVC));

  assert_cpu_second_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_svc_en && in_cpu_en) |=> (s1_src == SRC_CPU));

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);

  assert_no_ovf_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_ovf);

  assert_none_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && !cfg_we && cfg_sel == TSEL_NONE) |=> (cfg_rdata == '0));

endmodule

// File: tb/tb_qres_resolver.sv
module tb_qres_resolver;

  localparam int SPROF_W = 2;
  localparam int CODE_W  = 4;
  localparam int PRI_W   = 4;
  localparam int HASH_W  = 4;
  localparam int NBASE   = 192;
  localparam int NPRI    = 256;
  localparam int NHASH   = 256;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [1:0]        in_sprof = '0;
  logic              in_svc_en = 1'b0;
  logic [3:0]        in_svc_code = '0;
  logic              in_cpu_en = 1'b0;
  logic [3:0]        in_cpu_code = '0;
  logic [3:0]        in_dport = '0;
  logic [3:0]        in_pri = '0;
  logic [3:0]        in_hash = '0;
  logic              out_valid;
  logic [7:0]        out_qid;
  logic              out_ovf;
  logic              cfg_en = 1'b0;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_sel = '0;
  logic [11:0]       cfg_idx = '0;
  logic [11:0]       cfg_wdata = '0;
  logic [11:0]       cfg_rdata;

  always #2 clk = ~clk;

  qres_resolver dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sprof(in_sprof),
    .in_svc_en(in_svc_en), .in_svc_code(in_svc_code), .in_cpu_en(in_cpu_en),
    .in_cpu_code(in_cpu_code), .in_dport(in_dport), .in_pri(in_pri),
    .in_hash(in_hash), .out_valid(out_valid), .out_qid(out_qid),
    .out_ovf(out_ovf), .cfg_en(cfg_en), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic [11:0] sh_base [NBASE];
  logic [3:0]  sh_pri  [NPRI];
  logic [7:0]  sh_hash [NHASH];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Base address from the precedence and region rules (R1, R2)
  function automatic int model_bidx(int sp, bit sen, int sc, bit cen, int cc, int dp);
    int region, code;
    if (sen) begin region = 2; code = sc; end
    else if (cen) begin region = 1; code = cc; end
    else begin region = 0; code = dp; end
    return region * (1 << (SPROF_W + CODE_W)) + sp * (1 << CODE_W) + code;
  endfunction

  // Queue and overflow from the table contents (R3..R6)
  task automatic model_q(int bidx, int pri, int hash, output int qid, output int ovf);
    int ent, prof, qb, sum;
    ent  = int'(sh_base[bidx]);
    prof = ent % 16;
    qb   = ent / 16;
    sum  = qb + int'(sh_pri[prof * 16 + pri]) + int'(sh_hash[prof * 16 + hash]);
    qid  = sum % 256;
    ovf  = (sum > 255) ? 1 : 0;
  endtask

  task automatic set_in(int sp, bit sen, int sc, bit cen, int cc, int dp, int pri, int hash);
    in_valid    = 1'b1;
    in_sprof    = 2'(sp);
    in_svc_en   = sen;
    in_svc_code = 4'(sc);
    in_cpu_en   = cen;
    in_cpu_code = 4'(cc);
    in_dport    = 4'(dp);
    in_pri      = 4'(pri);
    in_hash     = 4'(hash);
  endtask

  task automatic lookup(string tag, int sp, bit sen, int sc, bit cen, int cc, int dp,
                        int pri, int hash);
    int eq, eo;
    model_q(model_bidx(sp, sen, sc, cen, cc, dp), pri, hash, eq, eo);
    set_in(sp, sen, sc, cen, cc, dp, pri, hash);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk({tag, " valid R8"}, 32'(out_valid), 1);
    chk({tag, " qid R6"}, 32'(out_qid), 32'(eq));
    chk({tag, " ovf R6"}, 32'(out_ovf), 32'(eo));
  endtask

  task automatic cfg_write(int sel, int idx, int data);
    cfg_en = 1'b1; cfg_we = 1'b1;
    cfg_sel = 2'(sel); cfg_idx = 12'(idx); cfg_wdata = 12'(data);
    @(posedge clk); @(negedge clk);
    cfg_en = 1'b0; cfg_we = 1'b0;
    if (sel == 0 && idx < NBASE) sh_base[idx] = 12'(data);
    if (sel == 1 && idx < NPRI)  sh_pri[idx]  = 4'(data);
    if (sel == 2 && idx < NHASH) sh_hash[idx] = 8'(data);
  endtask

  task automatic cfg_read(int sel, int idx, output int data);
    cfg_en = 1'b1; cfg_we = 1'b0;
    cfg_sel = 2'(sel); cfg_idx = 12'(idx);
    @(posedge clk); @(negedge clk);
    cfg_en = 1'b0;
    data = int'(cfg_rdata);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int rd, eq, eo, bidx, prof, pidx;
    for (int i = 0; i < NBASE; i++) sh_base[i] = '0;
    for (int i = 0; i < NPRI; i++)  sh_pri[i]  = '0;
    for (int i = 0; i < NHASH; i++) sh_hash[i] = '0;

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R7: reset state
    chk("reset out_valid R7", 32'(out_valid), 0);
    chk("reset out_ovf R7", 32'(out_ovf), 0);
    chk("reset cfg_rdata R7", 32'(cfg_rdata), 0);
    cfg_read(0, 100, rd); chk("reset base entry R7", 32'(rd), 0);
    cfg_read(2, 255, rd); chk("reset hash entry R7", 32'(rd), 0);
    lookup("reset lookup R7", 3, 1, 9, 0, 0, 0, 7, 11);

    // Fill every table with address-derived values
    for (int i = 0; i < NBASE; i++) cfg_write(0, i, (((i * 37) % 256) << 4) | ((i * 5) % 16));
    for (int i = 0; i < NPRI; i++)  cfg_write(1, i, ((i / 16) + (i % 16) * 3) % 16);
    for (int i = 0; i < NHASH; i++) cfg_write(2, i, ((i / 16) * 11 + (i % 16) * 29) % 256);

    // R3, R9: read-back
    cfg_read(0, 77, rd);  chk("base readback R3", 32'(rd), 32'(sh_base[77]));
    cfg_read(1, 200, rd); chk("pri readback R9", 32'(rd), 32'(sh_pri[200]));
    cfg_read(2, 123, rd); chk("hash readback R9", 32'(rd), 32'(sh_hash[123]));

    // R1, R2: every profile, every source mode, every code
    for (int sp = 0; sp < 4; sp++)
      for (int mode = 0; mode < 3; mode++)
        for (int c = 0; c < 16; c++) begin
          case (mode)
            0: lookup("sweep port R1 R2", sp, 0, (c + 3) % 16, 0, (c + 7) % 16, c,
                      (c + sp) % 16, (c * 3) % 16);
            1: lookup("sweep cpu R1 R2", sp, 0, (c + 3) % 16, 1, c, (c + 9) % 16,
                      (c + sp) % 16, (c * 3 + 1) % 16);
            default: lookup("sweep svc R1 R2", sp, 1, c, 1, (c + 5) % 16, (c + 9) % 16,
                            (c + sp) % 16, (c * 3 + 2) % 16);
          endcase
        end

    // R4: all priorities on one row; R5: all hashes
    for (int p = 0; p < 16; p++) lookup("pri sweep R4", 1, 0, 0, 0, 0, 5, p, 0);
    for (int h = 0; h < 16; h++) lookup("hash sweep R5", 2, 0, 0, 1, 6, 0, 0, h);

    // R6: boundary sums on profile 2 via base entry 19 (port region, sp 1, port 3)
    cfg_write(0, 19, (250 << 4) | 2);
    cfg_write(1, 32 + 15, 15);
    cfg_write(2, 32 + 15, 255);
    cfg_write(1, 32 + 14, 5);
    cfg_write(2, 32 + 14, 0);
    cfg_write(1, 32 + 13, 6);
    lookup("sum 520 wraps R6", 1, 0, 0, 0, 0, 3, 15, 15);
    chk("sum 520 value R6", 32'(out_qid), 8);
    lookup("sum 255 no ovf R6", 1, 0, 0, 0, 0, 3, 14, 14);
    chk("sum 255 flag R6", 32'(out_ovf), 0);
    lookup("sum 256 R6", 1, 0, 0, 0, 0, 3, 13, 14);
    chk("sum 256 flag R6", 32'(out_ovf), 1);

    // R8: out_valid falls after an idle cycle
    @(posedge clk); @(negedge clk);
    chk("idle out_valid R8", 32'(out_valid), 0);
    chk("idle out_ovf R6", 32'(out_ovf), 0);

    // R10: base write alongside the lookup that reads it
    bidx = model_bidx(1, 0, 0, 0, 0, 3);
    model_q(bidx, 4, 4, eq, eo);
    set_in(1, 0, 0, 0, 0, 3, 4, 4);
    cfg_en = 1'b1; cfg_we = 1'b1; cfg_sel = 2'd0; cfg_idx = 12'(bidx);
    cfg_wdata = 12'((40 << 4) | 7);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; cfg_en = 1'b0; cfg_we = 1'b0;
    sh_base[bidx] = 12'((40 << 4) | 7);
    @(posedge clk); @(negedge clk);
    chk("same-cycle base write unseen R10", 32'(out_qid), 32'(eq));
    lookup("base write seen later R10", 1, 0, 0, 0, 0, 3, 4, 4);

    // R10: priority write during the offset stage
    prof = int'(sh_base[bidx]) % 16;
    pidx = prof * 16 + 9;
    model_q(bidx, 9, 0, eq, eo);
    set_in(1, 0, 0, 0, 0, 3, 9, 0);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    cfg_en = 1'b1; cfg_we = 1'b1; cfg_sel = 2'd1; cfg_idx = 12'(pidx);
    cfg_wdata = 12'(int'(sh_pri[pidx]) ^ 4'hA);
    @(posedge clk); @(negedge clk);
    cfg_en = 1'b0; cfg_we = 1'b0;
    sh_pri[pidx] = sh_pri[pidx] ^ 4'hA;
    chk("same-cycle pri write unseen R10", 32'(out_qid), 32'(eq));
    lookup("pri write seen later R10", 1, 0, 0, 0, 0, 3, 9, 0);

    // R9: ignored writes and reads
    rd = int'(sh_base[0]);
    cfg_write(0, NBASE, 12'hABC);
    cfg_read(0, NBASE, rd); chk("out-of-range base reads zero R9", 32'(rd), 0);
    cfg_read(0, NBASE - 192, rd); chk("out-of-range write no alias R9", 32'(rd), 32'(sh_base[0]));
    cfg_write(3, 0, 12'hFFF);
    cfg_read(3, 0, rd); chk("select 3 reads zero R9", 32'(rd), 0);
    cfg_read(0, 0, rd); chk("select 3 base untouched R9", 32'(rd), 32'(sh_base[0]));
    cfg_read(1, 0, rd); chk("select 3 pri untouched R9", 32'(rd), 32'(sh_pri[0]));
    cfg_read(2, 0, rd); chk("select 3 hash untouched R9", 32'(rd), 32'(sh_hash[0]));
    cfg_write(1, 50, 12'hFF7);
    cfg_read(1, 50, rd); chk("pri entry width R9", 32'(rd), 7);
    cfg_write(2, 300, 12'h055);
    cfg_read(2, 300, rd); chk("hash past end reads zero R9", 32'(rd), 0);
    lookup("lookup after ignored writes R9", 0, 0, 0, 0, 0, 0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule